// File: doc/BRIEF.md
# Coherent Split-Byte Register Bridge

This block sits between an 8-bit processor bus and the 16-bit word side of a serial peripheral. The bus sees the 16-bit data word and the 16-bit match word as two byte addresses each, one for the upper byte and one for the lower byte. The bridge makes sure that the two bytes always belong to the same 16-bit value, whichever byte the processor touches first.

In wide (16-bit) mode, a data read freezes the whole live receive word in a holding register. The partner byte then comes from that same snapshot. Data writes and match writes are collected in staging registers. The staged word moves on only when both halves are present: to the transmit side as a one-cycle push, or into the match register. In narrow (8-bit) mode, the lower data byte alone is enough to start a transmit push. The serial shifter and the transmit buffer lie outside the block; the only signal the bridge sees from the buffer is its empty flag.

Top module: `spi_word_regbridge`

## Requirements
- R1: After reset, `rd_data`, `tx_push` and `tx_word` are zero, and `match_word` equals the parameter `MATCH_INIT` (default zero). The internal mode reference resets to narrow mode.
- R2: Byte addresses are 0 = data upper, 1 = data lower, 2 = match upper, 3 = match lower. `rd_data` is registered and carries the read byte in the cycle after `rd_en`. In any other cycle it is zero. A read asserted together with `wr_en` is ignored.
- R3: In wide mode, when no snapshot is held, a read of either data byte stores the full current `rx_word` as a snapshot and returns the requested byte of that snapshot.
- R4: While a snapshot is held, data reads return the snapshot and ignore `rx_word`. A read of the byte opposite to the one that took the snapshot releases it. A repeated read of the first byte keeps it.
- R5: In wide mode, data writes are staged. Once both the upper and the lower byte have been written, in either order, `tx_push` is high for exactly one cycle in the cycle after the completing write, with `tx_word` = {upper, lower}. `tx_word` changes only together with `tx_push`.
- R6: A second write to the same data or match byte before its partner replaces the staged byte and causes no commit.
- R7: Match writes are staged the same way. `match_word` takes {upper, lower} in the cycle after the completing write and changes at no other time. Match reads return the current `match_word` bytes directly.
- R8: In narrow mode, a write to address 1 pushes {0, byte}, a write to address 3 sets `match_word` to {0, byte}, and writes to addresses 0 and 2 are ignored. A read of address 1 returns the live `rx_word[7:0]`, and a read of address 0 returns zero.
- R9: A cycle in which `wide_mode` differs from its previous value discards all staged bytes and any snapshot. Any access in that cycle is ignored.
- R10: A completing data write made while `tx_empty` is low produces no push, and the staged pair is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Byte address of the access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 8 | Write byte |
| wide_mode | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| rx_word | input | 16 | Live received word |
| tx_empty | input | 1 | Transmit buffer can accept a word |
| rd_data | output | 8 | Registered read byte |
| tx_push | output | 1 | One-cycle commit pulse to the transmit buffer |
| tx_word | output | 16 | Word committed with the last push |
| match_word | output | 16 | Current match value |

## Verification
Every result of this block is registered once. Read bytes, the transmit push with its word, and the match value are all due exactly one clock after the access that causes them. The flush after a mode flip takes effect in the flip cycle itself. The bench applies each access at a falling edge and compares all four outputs at the next falling edge, against a model that advances by one access per cycle. Because of this, a result that arrives one cycle early or late shows up as a mismatch.

// File: rtl/spi_wrb_pkg.sv
package spi_wrb_pkg;

   typedef enum logic [1:0] {
      SEL_DHI = 2'd0,
      SEL_DLO = 2'd1,
      SEL_MHI = 2'd2,
      SEL_MLO = 2'd3
   } sel_e;

   function automatic logic sel_is_hi(input sel_e s);
      return (s == SEL_DHI) || (s == SEL_MHI);
   endfunction

endpackage

// File: rtl/byte_pair_stager.sv
module byte_pair_stager #(
   parameter int BYTE_W = 8,
   localparam int WORD_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wide,
   input  logic              wr_hi,
   input  logic              wr_lo,
   input  logic [BYTE_W-1:0] wdata,
   output logic              done,
   output logic [WORD_W-1:0] word
);

   logic              got_hi_q, got_lo_q;
   logic [BYTE_W-1:0] st_hi_q, st_lo_q;

   always_comb begin
      if (wide) begin
         done = (wr_hi && got_lo_q) || (wr_lo && got_hi_q);
         word = {(wr_hi ? wdata : st_hi_q), (wr_lo ? wdata : st_lo_q)};
      end else begin
         done = wr_lo;
         word = {{BYTE_W{1'b0}}, wdata};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         got_hi_q <= 1'b0;
         got_lo_q <= 1'b0;
         st_hi_q  <= '0;
         st_lo_q  <= '0;
      end else if (flush) begin
         got_hi_q <= 1'b0;
         got_lo_q <= 1'b0;
      end else if (wide) begin
         if (done) begin
            got_hi_q <= 1'b0;
            got_lo_q <= 1'b0;
         end else if (wr_hi) begin
            st_hi_q  <= wdata;
            got_hi_q <= 1'b1;
         end else if (wr_lo) begin
            st_lo_q  <= wdata;
            got_lo_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/coherent_read_hold.sv
module coherent_read_hold #(
   parameter int WORD_W      = 16,
   parameter bit HOLD_ENABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              rd,
   input  logic              rd_hi,
   input  logic [WORD_W-1:0] live,
   output logic [WORD_W-1:0] view
);

   generate
      if (HOLD_ENABLE) begin : g_hold
         logic [WORD_W-1:0] snap_q;
         logic              held_q, first_hi_q;

         assign view = held_q ? snap_q : live;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               snap_q     <= '0;
               held_q     <= 1'b0;
               first_hi_q <= 1'b0;
            end else if (flush) begin
               held_q <= 1'b0;
            end else if (rd) begin
               if (!held_q) begin
                  snap_q     <= live;
                  held_q     <= 1'b1;
                  first_hi_q <= rd_hi;
               end else if (rd_hi != first_hi_q) begin
                  held_q <= 1'b0;
               end
            end
         end
      end else begin : g_pass
         logic unused_ok;
         assign unused_ok = &{1'b0, clk, rst_n, flush, rd, rd_hi};
         assign view = live;
      end
   endgenerate

endmodule

// File: rtl/spi_word_regbridge.sv
module spi_word_regbridge
   import spi_wrb_pkg::*;
#(
   parameter int          BYTE_W      = 8,
   parameter int          WORD_W      = 16,
   parameter bit          HOLD_ENABLE = 1'b1,
   parameter logic [15:0] MATCH_INIT  = 16'h0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        addr,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              wide_mode,
   input  logic [WORD_W-1:0] rx_word,
   input  logic              tx_empty,
   output logic [BYTE_W-1:0] rd_data,
   output logic              tx_push,
   output logic [WORD_W-1:0] tx_word,
   output logic [WORD_W-1:0] match_word
);

   localparam int HI_MSB = WORD_W - 1;
   localparam int LO_MSB = BYTE_W - 1;

   generate
      if (WORD_W != 2 * BYTE_W) begin : g_bad_width
         $error("spi_word_regbridge: WORD_W must be twice BYTE_W");
      end
      if (WORD_W != 16) begin : g_bad_init
         $error("spi_word_regbridge: MATCH_INIT is sized for 16-bit words");
      end
   endgenerate

   sel_e sel;
   logic mode_q, flush, wr_ok, rd_ok, sel_data;
   logic dat_done, mat_done;
   logic [WORD_W-1:0] dat_word, mat_word, view;
   logic [BYTE_W-1:0] rd_next;

   assign sel      = sel_e'(addr);
   assign flush    = (wide_mode != mode_q);
   assign wr_ok    = wr_en && !flush;
   assign rd_ok    = rd_en && !wr_en && !flush;
   assign sel_data = (sel == SEL_DHI) || (sel == SEL_DLO);

   byte_pair_stager #(.BYTE_W(BYTE_W)) u_dat_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .wide  (wide_mode),
      .wr_hi (wr_ok && sel == SEL_DHI),
      .wr_lo (wr_ok && sel == SEL_DLO),
      .wdata (wr_data),
      .done  (dat_done),
      .word  (dat_word)
   );

   byte_pair_stager #(.BYTE_W(BYTE_W)) u_mat_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .wide  (wide_mode),
      .wr_hi (wr_ok && sel == SEL_MHI),
      .wr_lo (wr_ok && sel == SEL_MLO),
      .wdata (wr_data),
      .done  (mat_done),
      .word  (mat_word)
   );

   coherent_read_hold #(.WORD_W(WORD_W), .HOLD_ENABLE(HOLD_ENABLE)) u_rd_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .rd    (rd_ok && wide_mode && sel_data),
      .rd_hi (sel_is_hi(sel)),
      .live  (rx_word),
      .view  (view)
   );

   always_comb begin
      rd_next = '0;
      if (rd_ok) begin
         unique case (sel)
            SEL_DHI: rd_next = wide_mode ? view[HI_MSB -: BYTE_W] : '0;
            SEL_DLO: rd_next = wide_mode ? view[LO_MSB:0] : rx_word[LO_MSB:0];
            SEL_MHI: rd_next = match_word[HI_MSB -: BYTE_W];
            SEL_MLO: rd_next = match_word[LO_MSB:0];
            default: rd_next = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= 1'b0;
         rd_data    <= '0;
         tx_push    <= 1'b0;
         tx_word    <= '0;
         match_word <= MATCH_INIT[WORD_W-1:0];
      end else begin
         mode_q  <= wide_mode;
         rd_data <= rd_next;
         tx_push <= dat_done && tx_empty;
         if (dat_done && tx_empty) tx_word <= dat_word;
         if (mat_done) match_word <= mat_word;
      end
   end

endmodule

// File: rtl/spi_wrb_chk.sv
module spi_wrb_chk #(
   parameter int BYTE_W = 8,
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic              wr_en,
   input logic              wide_mode,
   input logic              tx_empty,
   input logic [BYTE_W-1:0] rd_data,
   input logic              tx_push,
   input logic [WORD_W-1:0] tx_word,
   input logic [WORD_W-1:0] match_word
);

   // R10
   push_needs_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_push |-> ($past(tx_empty) && $past(wr_en)));

   // R9
   mode_flip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wide_mode != $past(wide_mode)) |=> !tx_push);

   // R7
   match_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(match_word));

   // R5
   tx_word_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_push |-> $stable(tx_word));

   // R2
   rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rd_data == '0));

endmodule

bind spi_word_regbridge spi_wrb_chk #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_en      (rd_en),
   .wr_en      (wr_en),
   .wide_mode  (wide_mode),
   .tx_empty   (tx_empty),
   .rd_data    (rd_data),
   .tx_push    (tx_push),
   .tx_word    (tx_word),
   .match_word (match_word)
);

// File: tb/tb_spi_word_regbridge.sv
`timescale 1ns/1ps
module tb_spi_word_regbridge;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  addr = '0;
   logic        rd_en = 1'b0, wr_en = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        wide_mode = 1'b0;
   logic [15:0] rx_word = '0;
   logic        tx_empty = 1'b1;
   logic [7:0]  rd_data;
   logic        tx_push;
   logic [15:0] tx_word, match_word;

   int total = 0, bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   spi_word_regbridge dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
      .wr_data(wr_data), .wide_mode(wide_mode), .rx_word(rx_word),
      .tx_empty(tx_empty), .rd_data(rd_data), .tx_push(tx_push),
      .tx_word(tx_word), .match_word(match_word)
   );

   // model state
   bit          m_mode, m_gh, m_gl, m_mgh, m_mgl, m_hold, m_first_hi;
   logic [7:0]  m_sh, m_sl, m_msh, m_msl;
   logic [15:0] m_cap, m_tx, m_match;
   logic [7:0]  e_rd;
   bit          e_push;

   function automatic logic [7:0] pick(input logic [15:0] w, input bit hi);
      return hi ? w[15:8] : w[7:0];
   endfunction

   task automatic model(input bit rd, input bit wr, input logic [1:0] a,
                        input logic [7:0] wd, input logic [15:0] rx,
                        input bit empty, input bit wide);
      bit flush = (wide != m_mode);
      e_rd = '0; e_push = 1'b0;
      m_mode = wide;
      if (flush) begin
         m_gh = 0; m_gl = 0; m_mgh = 0; m_mgl = 0; m_hold = 0;
      end else if (wr) begin
         if (!wide) begin
            if (a == 2'd1 && empty) begin e_push = 1; m_tx = {8'h00, wd}; end
            if (a == 2'd3) m_match = {8'h00, wd};
         end else if (a == 2'd0 || a == 2'd1) begin
            if (a == 2'd0) begin m_sh = wd; m_gh = 1; end
            else begin m_sl = wd; m_gl = 1; end
            if (m_gh && m_gl) begin
               if (empty) begin e_push = 1; m_tx = {m_sh, m_sl}; end
               m_gh = 0; m_gl = 0;
            end
         end else begin
            if (a == 2'd2) begin m_msh = wd; m_mgh = 1; end
            else begin m_msl = wd; m_mgl = 1; end
            if (m_mgh && m_mgl) begin
               m_match = {m_msh, m_msl}; m_mgh = 0; m_mgl = 0;
            end
         end
      end else if (rd) begin
         if (a == 2'd2) e_rd = m_match[15:8];
         else if (a == 2'd3) e_rd = m_match[7:0];
         else if (!wide) e_rd = (a == 2'd1) ? rx[7:0] : 8'h00;
         else begin
            if (!m_hold) begin
               m_cap = rx; m_hold = 1; m_first_hi = (a == 2'd0);
            end else if ((a == 2'd0) != m_first_hi) m_hold = 0;
            e_rd = pick(m_cap, a == 2'd0);
         end
      end
   endtask

   task automatic check(input string tag, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // one access: drive at a falling edge, compare at the next falling edge
   task automatic step(input bit rd, input bit wr, input logic [1:0] a,
                       input logic [7:0] wd, input logic [15:0] rx,
                       input bit empty, input bit wide, input string tag);
      rd_en = rd; wr_en = wr; addr = a; wr_data = wd; rx_word = rx;
      tx_empty = empty; wide_mode = wide;
      model(rd, wr, a, wd, rx, empty, wide);
      @(negedge clk);
      rd_en = 1'b0; wr_en = 1'b0;
      check(tag, "rd_data", {8'h00, rd_data}, {8'h00, e_rd});
      check(tag, "tx_push", {15'd0, tx_push}, {15'd0, e_push});
      check(tag, "tx_word", tx_word, m_tx);
      check(tag, "match_word", match_word, m_match);
   endtask

   task automatic summary;
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      m_mode = 0; m_gh = 0; m_gl = 0; m_mgh = 0; m_mgl = 0; m_hold = 0;
      m_first_hi = 0; m_sh = 0; m_sl = 0; m_msh = 0; m_msl = 0;
      m_cap = 0; m_tx = 0; m_match = 0;
      repeat (3) @(negedge clk);
      // R1 reset values
      check("R1", "rd_data", {8'h00, rd_data}, 16'h0000);
      check("R1", "tx_push", {15'd0, tx_push}, 16'h0000);
      check("R1", "tx_word", tx_word, 16'h0000);
      check("R1", "match_word", match_word, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 entering wide mode: flip cycle, access ignored
      step(0, 1, 2'd1, 8'h77, 16'h0, 1, 1, "R9");
      // R5 upper then lower
      step(0, 1, 2'd0, 8'hA5, 16'h0, 1, 1, "R5");
      step(0, 1, 2'd1, 8'h5A, 16'h0, 1, 1, "R5");
      check("R5", "pushed word", tx_word, 16'hA55A);
      // R5 lower then upper
      step(0, 1, 2'd1, 8'h34, 16'h0, 1, 1, "R5");
      step(0, 1, 2'd0, 8'h12, 16'h0, 1, 1, "R5");
      check("R5", "pushed word", tx_word, 16'h1234);
      // R6 overwrite before partner
      step(0, 1, 2'd0, 8'h11, 16'h0, 1, 1, "R6");
      step(0, 1, 2'd0, 8'h22, 16'h0, 1, 1, "R6");
      step(0, 1, 2'd1, 8'h33, 16'h0, 1, 1, "R6");
      check("R6", "pushed word", tx_word, 16'h2233);
      // R10 no room: no push, pair discarded
      step(0, 1, 2'd0, 8'h44, 16'h0, 1, 1, "R10");
      step(0, 1, 2'd1, 8'h55, 16'h0, 0, 1, "R10");
      step(0, 1, 2'd1, 8'h66, 16'h0, 1, 1, "R10");
      check("R10", "no push after discard", {15'd0, tx_push}, 16'h0000);
      step(0, 1, 2'd0, 8'h77, 16'h0, 1, 1, "R10");
      check("R10", "pushed word", tx_word, 16'h7766);
      // R3/R4 coherent read, first byte upper
      step(1, 0, 2'd0, 8'h0, 16'hBEEF, 1, 1, "R3");
      check("R3", "upper of snapshot", {8'h00, rd_data}, 16'h00BE);
      step(1, 0, 2'd0, 8'h0, 16'h1111, 1, 1, "R4");
      step(1, 0, 2'd1, 8'h0, 16'h2222, 1, 1, "R4");
      check("R4", "lower of snapshot", {8'h00, rd_data}, 16'h00EF);
      step(1, 0, 2'd1, 8'h0, 16'hC0DE, 1, 1, "R3");
      check("R3", "new snapshot lower", {8'h00, rd_data}, 16'h00DE);
      step(1, 0, 2'd0, 8'h0, 16'h9999, 1, 1, "R4");
      check("R4", "upper of second snapshot", {8'h00, rd_data}, 16'h00C0);
      // R7 match staging and direct read
      step(0, 1, 2'd3, 8'hCD, 16'h0, 1, 1, "R7");
      check("R7", "match unchanged", match_word, 16'h0000);
      step(0, 1, 2'd2, 8'hAB, 16'h0, 1, 1, "R7");
      check("R7", "match committed", match_word, 16'hABCD);
      step(1, 0, 2'd2, 8'h0, 16'h0, 1, 1, "R7");
      step(1, 0, 2'd3, 8'h0, 16'h0, 1, 1, "R7");
      // R9 flip clears staged upper byte
      step(0, 1, 2'd0, 8'hF0, 16'h0, 1, 1, "R9");
      step(0, 0, 2'd0, 8'h00, 16'h0, 1, 0, "R9");
      // R8 narrow mode
      step(0, 1, 2'd1, 8'h3C, 16'h0, 1, 0, "R8");
      check("R8", "narrow push", tx_word, 16'h003C);
      step(0, 1, 2'd0, 8'hEE, 16'h0, 1, 0, "R8");
      step(0, 1, 2'd3, 8'h81, 16'h0, 1, 0, "R8");
      check("R8", "narrow match", match_word, 16'h0081);
      step(1, 0, 2'd1, 8'h0, 16'h4321, 1, 0, "R8");
      check("R8", "live lower", {8'h00, rd_data}, 16'h0021);
      step(1, 0, 2'd0, 8'h0, 16'h4321, 1, 0, "R8");
      step(0, 0, 2'd0, 8'h00, 16'h0, 1, 1, "R9");
      step(0, 1, 2'd1, 8'h09, 16'h0, 1, 1, "R9");
      check("R9", "staged upper was discarded", {15'd0, tx_push}, 16'h0000);
      step(0, 1, 2'd0, 8'h08, 16'h0, 1, 1, "R9");
      check("R9", "pair after flush", tx_word, 16'h0809);

      // R2 constrained random mix
      for (int i = 0; i < 4000; i++) begin
         int unsigned r = $urandom % 16;
         bit w = wide_mode;
         if (r == 0) w = ~w;
         step((r >= 8), (r >= 1 && r < 8), 2'($urandom % 4), 8'($urandom),
              16'($urandom), (($urandom % 5) != 0), w, "R2");
      end

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule